// File: doc/BRIEF.md
# Sign-Magnitude Adder with Saturation

This block adds two operands held in sign-magnitude form and returns the sum in the same form. Each operand is turned into two's complement at one bit more than the operand width, so the addition itself is a plain binary add that cannot wrap. The sum is then turned back into sign-magnitude and presented in two ways. The first is a full-range result with one extra magnitude bit, which is always exact. The second is an operand-width result that clamps to the largest representable magnitude and raises an overflow flag when the true magnitude does not fit.

A negative-zero operand counts as zero. A zero result always comes out with a cleared sign bit. A parameter selects the output path. The path is either purely combinational, or it has one register stage. In the registered path, a valid strobe travels alongside the data and a synchronous reset clears both.

Top module: `smag_adder`

## Requirements
- R1: An operand is OP_W (default 6) bits wide. Bit OP_W-1 is the sign (1 = negative) and bits OP_W-2..0 are the unsigned magnitude. In both results the top bit is the sign of the arithmetic sum, set only when the sum is below zero.
- R2: `sum_full_o` holds the exact sum for every operand pair. Its sign bit is bit OP_W and its magnitude is bits OP_W-1..0, covering magnitudes up to 2*(2^(OP_W-1)-1), which is 62 at the default width.
- R3: When the sum's magnitude is at most 2^(OP_W-1)-1 (31 at the default width), `ovf_o` is 0. `sum_sat_o` then holds the sign of the sum in bit OP_W-1 and the exact magnitude in bits OP_W-2..0.
- R4: When the sum's magnitude exceeds 2^(OP_W-1)-1, `ovf_o` is 1. `sum_sat_o` then holds a magnitude of 2^(OP_W-1)-1 and the sign of the sum.
- R5: An operand with sign 1 and magnitude 0 gives the same results as positive zero.
- R6: A zero sum is output with sign bit 0 on both `sum_full_o` and `sum_sat_o`.
- R7: With PATH = PATH_REG, operands sampled at a rising clock edge with `in_valid` = 1 appear on the outputs after that edge. `out_valid` equals `in_valid` as sampled at the previous edge.
- R8: With PATH = PATH_REG, a synchronous reset (`rst` = 1 at a rising edge) clears `sum_full_o`, `sum_sat_o`, `ovf_o` and `out_valid` to 0.
- R9: With PATH = PATH_COMB, the outputs follow the operands within the same cycle and `out_valid` equals `in_valid`.
- R10: With PATH = PATH_REG, an edge with `in_valid` = 0 leaves `sum_full_o`, `sum_sat_o` and `ovf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_i | input | OP_W | First operand, sign-magnitude |
| b_i | input | OP_W | Second operand, sign-magnitude |
| out_valid | output | 1 | Results are valid |
| sum_full_o | output | OP_W+1 | Exact sum, sign-magnitude |
| sum_sat_o | output | OP_W | Clamped sum, sign-magnitude |
| ovf_o | output | 1 | Clamped result differs from the exact one |

## Verification
The combinational instance's results are due in the same cycle the operands are driven. The bench samples them 1 ns after it drives the inputs on the falling edge. The registered instance's results and `out_valid` are due one rising edge later, so the bench samples them 1 ns after that edge and compares against the reference for the operands it drove half a cycle earlier. Cycles with `in_valid` low are checked against the last value the bench's model accepted. A reset is checked as clearing the outputs at the first edge at which it is sampled.

// File: rtl/smag_pkg.sv
package smag_pkg;

   typedef enum logic {
      PATH_COMB = 1'b0,
      PATH_REG  = 1'b1
   } path_e;

   localparam int unsigned SMAG_DEF_W = 6;

endpackage

// File: rtl/smag_to_tc.sv
module smag_to_tc #(
   parameter int unsigned OP_W = 6,
   parameter int unsigned TC_W = OP_W + 1
) (
   input  logic [OP_W-1:0] smag_i,
   output logic [TC_W-1:0] tc_o
);
   localparam int unsigned MAG_W = OP_W - 1;

   logic             is_neg;
   logic [MAG_W-1:0] mag;
   logic [TC_W-1:0]  mag_ext;
   logic [TC_W-1:0]  one;

   assign is_neg  = smag_i[OP_W-1];
   assign mag     = smag_i[MAG_W-1:0];
   assign mag_ext = {{(TC_W-MAG_W){1'b0}}, mag};
   assign one     = {{(TC_W-1){1'b0}}, 1'b1};

   always_comb begin
      if (mag == '0) begin
         // negative zero and positive zero both map to zero
         tc_o = '0;
      end else if (is_neg) begin
         tc_o = ~mag_ext + one;
      end else begin
         tc_o = mag_ext;
      end
   end
endmodule

// File: rtl/tc_to_smag.sv
module tc_to_smag #(
   parameter int unsigned OP_W = 6,
   parameter int unsigned TC_W = OP_W + 1
) (
   input  logic [TC_W-1:0] tc_i,
   output logic [OP_W:0]   full_o,
   output logic [OP_W-1:0] sat_o,
   output logic            ovf_o
);
   localparam int unsigned MAG_W = OP_W - 1;

   logic             neg;
   logic [TC_W-1:0]  absv;
   logic [TC_W-1:0]  one;
   logic             sign_out;
   logic             over;
   logic [MAG_W-1:0] sat_mag;

   assign one = {{(TC_W-1){1'b0}}, 1'b1};
   assign neg = tc_i[TC_W-1];

   always_comb begin
      if (neg) absv = ~tc_i + one;
      else     absv = tc_i;
   end

   // sign only when the magnitude is non-zero: no negative zero
   assign sign_out = neg & (|absv);
   assign over     = |absv[TC_W-1:MAG_W];
   assign sat_mag  = over ? {MAG_W{1'b1}} : absv[MAG_W-1:0];

   assign full_o = {sign_out, absv[OP_W-1:0]};
   assign sat_o  = {sign_out, sat_mag};
   assign ovf_o  = over;
endmodule

// File: rtl/smag_out_stage.sv
module smag_out_stage
   import smag_pkg::*;
#(
   parameter path_e       PATH   = PATH_REG,
   parameter int unsigned FULL_W = 7,
   parameter int unsigned SAT_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic [FULL_W-1:0] full_i,
   input  logic [SAT_W-1:0]  sat_i,
   input  logic              ovf_i,
   output logic              vld_o,
   output logic [FULL_W-1:0] full_o,
   output logic [SAT_W-1:0]  sat_o,
   output logic              ovf_o
);
   generate
      if (PATH == PATH_REG) begin : g_reg
         logic              vld_q;
         logic [FULL_W-1:0] full_q;
         logic [SAT_W-1:0]  sat_q;
         logic              ovf_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q  <= 1'b0;
               full_q <= '0;
               sat_q  <= '0;
               ovf_q  <= 1'b0;
            end else begin
               vld_q <= vld_i;
               if (vld_i) begin
                  full_q <= full_i;
                  sat_q  <= sat_i;
                  ovf_q  <= ovf_i;
               end
            end
         end

         assign vld_o  = vld_q;
         assign full_o = full_q;
         assign sat_o  = sat_q;
         assign ovf_o  = ovf_q;
      end else begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst;
         assign vld_o  = vld_i;
         assign full_o = full_i;
         assign sat_o  = sat_i;
         assign ovf_o  = ovf_i;
      end
   endgenerate
endmodule

// File: rtl/smag_adder.sv
module smag_adder
   import smag_pkg::*;
#(
   parameter int unsigned OP_W = SMAG_DEF_W,
   parameter path_e       PATH = PATH_REG
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [OP_W-1:0] a_i,
   input  logic [OP_W-1:0] b_i,
   output logic            out_valid,
   output logic [OP_W:0]   sum_full_o,
   output logic [OP_W-1:0] sum_sat_o,
   output logic            ovf_o
);
   localparam int unsigned TC_W   = OP_W + 1;
   localparam int unsigned FULL_W = OP_W + 1;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("smag_adder: OP_W must be at least 2");
      end
   endgenerate

   logic [TC_W-1:0]   a_tc;
   logic [TC_W-1:0]   b_tc;
   logic [TC_W-1:0]   sum_tc;
   logic [FULL_W-1:0] full_d;
   logic [OP_W-1:0]   sat_d;
   logic              ovf_d;

   smag_to_tc #(.OP_W(OP_W), .TC_W(TC_W)) u_cvt_a (.smag_i(a_i), .tc_o(a_tc));
   smag_to_tc #(.OP_W(OP_W), .TC_W(TC_W)) u_cvt_b (.smag_i(b_i), .tc_o(b_tc));

   // one extra bit keeps the plain binary add from wrapping
   assign sum_tc = a_tc + b_tc;

   tc_to_smag #(.OP_W(OP_W), .TC_W(TC_W)) u_back (
      .tc_i   (sum_tc),
      .full_o (full_d),
      .sat_o  (sat_d),
      .ovf_o  (ovf_d)
   );

   smag_out_stage #(.PATH(PATH), .FULL_W(FULL_W), .SAT_W(OP_W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (in_valid),
      .full_i (full_d),
      .sat_i  (sat_d),
      .ovf_i  (ovf_d),
      .vld_o  (out_valid),
      .full_o (sum_full_o),
      .sat_o  (sum_sat_o),
      .ovf_o  (ovf_o)
   );
endmodule

// File: rtl/smag_adder_chk.sv
module smag_adder_chk
   import smag_pkg::*;
#(
   parameter int unsigned OP_W = SMAG_DEF_W,
   parameter path_e       PATH = PATH_REG
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            out_valid,
   input logic [OP_W:0]   sum_full_o,
   input logic [OP_W-1:0] sum_sat_o,
   input logic            ovf_o
);
   localparam int unsigned MAG_W   = OP_W - 1;
   localparam int unsigned SAT_MAX = (1 << MAG_W) - 1;

   logic [OP_W-1:0]  full_mag;
   logic [MAG_W-1:0] sat_mag;
   assign full_mag = sum_full_o[OP_W-1:0];
   assign sat_mag  = sum_sat_o[MAG_W-1:0];

   AST_FULL_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
      (full_mag == '0) |-> !sum_full_o[OP_W]); // R6
   AST_SAT_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
      (sat_mag == '0) |-> !sum_sat_o[OP_W-1]); // R6
   AST_FULL_RANGE: assert property (@(posedge clk) disable iff (rst)
      32'(full_mag) <= 2 * SAT_MAX); // R2
   AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (rst)
      ovf_o |-> (32'(sat_mag) == SAT_MAX && 32'(full_mag) > SAT_MAX
                 && sum_sat_o[OP_W-1] == sum_full_o[OP_W])); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      !ovf_o |-> (32'(full_mag) <= SAT_MAX && sat_mag == full_mag[MAG_W-1:0]
                  && sum_sat_o[OP_W-1] == sum_full_o[OP_W])); // R3

   generate
      if (PATH == PATH_REG) begin : g_reg_chk
         AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R7
         AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid); // R7
         AST_HOLD: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(sum_full_o) && $stable(sum_sat_o) && $stable(ovf_o))); // R10
      end else begin : g_comb_chk
         AST_COMB_VALID: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid); // R9
      end
   endgenerate
endmodule

bind smag_adder smag_adder_chk #(.OP_W(OP_W), .PATH(PATH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .sum_full_o (sum_full_o),
   .sum_sat_o  (sum_sat_o),
   .ovf_o      (ovf_o)
);

// File: tb/tb_smag_adder.sv
`timescale 1ns/1ps
module tb_smag_adder;
   import smag_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [5:0] a_i = '0;
   logic [5:0] b_i = '0;

   logic       ov_r, ov_c, of_r, of_c;
   logic [6:0] fu_r, fu_c;
   logic [5:0] sa_r, sa_c;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [6:0] last_full = '0;
   logic [5:0] last_sat = '0;
   logic       last_ovf = 1'b0;

   always #10 clk = ~clk;

   smag_adder #(.OP_W(6), .PATH(PATH_REG)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
      .out_valid(ov_r), .sum_full_o(fu_r), .sum_sat_o(sa_r), .ovf_o(of_r));

   smag_adder #(.OP_W(6), .PATH(PATH_COMB)) dut_c (
      .clk(clk), .rst(rst), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
      .out_valid(ov_c), .sum_full_o(fu_c), .sum_sat_o(sa_c), .ovf_o(of_c));

   function automatic int val(input logic [5:0] x);
      int m = int'(x[4:0]);
      return x[5] ? -m : m;
   endfunction

   function automatic logic [6:0] ref_full(input int s);
      int m = (s < 0) ? -s : s;
      return {(s < 0), 6'(m)};
   endfunction

   function automatic logic [5:0] ref_sat(input int s);
      int m = (s < 0) ? -s : s;
      if (m > 31) m = 31;
      return {(s < 0), 5'(m)};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic [5:0] a, input logic [5:0] b, input logic v);
      int s;
      logic [6:0] ef;
      logic [5:0] es;
      logic eo;
      string tf;
      s  = val(a) + val(b);
      ef = ref_full(s);
      es = ref_sat(s);
      eo = ((s < 0) ? -s : s) > 31;
      if (a == 6'b100000 || b == 6'b100000) tf = "R5";
      else if (s == 0) tf = "R6";
      else tf = "R2";
      @(negedge clk);
      a_i = a; b_i = b; in_valid = v;
      #1;
      chk(fu_c == ef, tf, int'(fu_c), int'(ef));
      chk(fu_c[6] == (s < 0), "R1", int'(fu_c[6]), int'(s < 0));
      chk(sa_c == es, eo ? "R4" : (s == 0 ? "R6" : "R3"), int'(sa_c), int'(es));
      chk(of_c == eo, eo ? "R4" : "R3", int'(of_c), int'(eo));
      chk(ov_c == v, "R9", int'(ov_c), int'(v));
      @(posedge clk);
      #1;
      chk(ov_r == v, "R7", int'(ov_r), int'(v));
      if (v) begin
         last_full = ef; last_sat = es; last_ovf = eo;
         chk(fu_r == ef, "R7", int'(fu_r), int'(ef));
      end else begin
         chk(fu_r == last_full, "R10", int'(fu_r), int'(last_full));
      end
      chk(sa_r == last_sat, v ? "R7" : "R10", int'(sa_r), int'(last_sat));
      chk(of_r == last_ovf, v ? "R7" : "R10", int'(of_r), int'(last_ovf));
   endtask

   task automatic check_cleared();
      chk(ov_r == 1'b0, "R8", int'(ov_r), 0);
      chk(fu_r == '0, "R8", int'(fu_r), 0);
      chk(sa_r == '0, "R8", int'(sa_r), 0);
      chk(of_r == 1'b0, "R8", int'(of_r), 0);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #1;
      check_cleared();
      @(negedge clk);
      rst = 1'b0;

      // directed corners
      step(6'b100000, 6'b000000, 1'b1);   // R5: negative zero + zero
      step(6'b100000, 6'b100000, 1'b1);   // R5
      step(6'b100000, 6'b000111, 1'b1);   // R5
      step(6'b000101, 6'b100101, 1'b1);   // R6: cancels to zero
      step(6'b111111, 6'b011111, 1'b1);   // R6
      step(6'b011111, 6'b000000, 1'b1);   // R3 edge 31
      step(6'b010000, 6'b010000, 1'b1);   // R4: 32
      step(6'b111111, 6'b111111, 1'b1);   // R4: -62
      step(6'b011111, 6'b011111, 1'b1);   // R2: +62
      step(6'b000011, 6'b000100, 1'b0);   // R10: hold
      step(6'b100001, 6'b100001, 1'b0);   // R10

      // mid-run reset, R8
      step(6'b011111, 6'b011111, 1'b1);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1; a_i = 6'b000001; b_i = 6'b000001;
      @(posedge clk);
      #1;
      check_cleared();
      last_full = '0; last_sat = '0; last_ovf = 1'b0;
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;

      // exhaustive sweep of every pair
      for (int i = 0; i < 64; i++) begin
         for (int j = 0; j < 64; j++) begin
            step(6'(i), 6'(j), 1'b1);
         end
      end

      // random operands with random valid
      for (int k = 0; k < 1500; k++) begin
         step(6'($urandom), 6'($urandom), 1'($urandom));
      end

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule